// File: doc/BRIEF.md
# Dual-Rail Four-Phase Half-Buffer Logic Cell

This block is a clocked, synthesizable behavioural model of one quasi-delay-insensitive pipeline cell. Each input lane carries one bit as a pair of rails, true and false. The cell computes a small logic function of its lanes and holds the result as a dual-rail output. It talks to its neighbours through a four-phase return-to-zero handshake: a right-side acknowledge comes in from the consumer, and a left-side acknowledge goes out to the producer.

The cell latches a result only when every lane it uses carries a valid code and the consumer acknowledge is low. It returns to the empty state only when every used lane is empty and the consumer acknowledge is high. In every other case it holds. The left acknowledge tells whether the output is valid, so in a chain a token sits in at most every second stage.

A parameter chooses the function: plain buffer, two-input AND, two-input XOR, or three-input AND-OR. Inverted copies of both output rails and of the acknowledge are also provided. A synchronous active-high reset puts the cell in its idle state.

Top module: `hb_cell`

## Requirements
- R1: Each lane and the output use a 2-bit code {true rail, false rail}. 00 is empty, 10 is logic 1, 01 is logic 0, and 11 is illegal. The output never shows 11.
- R2: A clock edge with `rst` high leaves `out_t`, `out_f` and `lack` at 0 at that edge, whatever the cell was doing.
- R3: If the output is empty, every used lane is valid and `rack` is 0, the next edge latches the function result and raises `lack`.
- R4: If the output is valid, every used lane is empty and `rack` is 1, the next edge returns the output to 00 and drops `lack`.
- R5: In every other combination the output holds. Valid lanes with `rack` high do not load, and a valid output with `rack` high stays put while the lanes are still valid.
- R6: If only some used lanes are valid, the output stays empty, even when the valid lanes alone would already decide the function (for example, C true in AND-OR).
- R7: `FUNC` selects the function over lanes A=bit0, B=bit1, C=bit2. FN_BUF: Q=A. FN_AND2: Q=A·B. FN_XOR2: Q=A⊕B. FN_AO3: Q=A·B+C. The false rail always carries the complement of the true rail.
- R8: `out_tn`, `out_fn` and `lack_n` are always the inverses of `out_t`, `out_f` and `lack`.
- R9: Lanes that the selected function does not use have no effect on either phase: lanes 1 and 2 for FN_BUF, lane 2 for FN_AND2 and FN_XOR2.
- R10: A used lane that carries 11 counts as neither valid nor empty, so the cell neither loads nor clears while it is present.
- R11: In a chain (each cell's `rack` fed by the next cell's `lack`), tokens leave the last cell in the order they entered, with their values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_t | input | 3 | True rails of lanes C,B,A (bit 2..0) |
| in_f | input | 3 | False rails of lanes C,B,A (bit 2..0) |
| rack | input | 1 | Acknowledge from the consumer |
| out_t | output | 1 | Output true rail |
| out_f | output | 1 | Output false rail |
| out_tn | output | 1 | Inverted output true rail |
| out_fn | output | 1 | Inverted output false rail |
| lack | output | 1 | Acknowledge to the producer (output valid) |
| lack_n | output | 1 | Inverted acknowledge to the producer |

## Verification
Suppose the held output state goes wrong, for example it loads early on a partial token or fails to clear. The error appears at `out_t`/`out_f` and `lack` at the very next clock edge after the input change that triggered it. In a chain, a wrong state then deadlocks the handshake or delivers a wrong or duplicated token at the far end within a few cycles. The bench therefore checks the output one edge after each input step, for every function and every input combination. It also checks the hold cases and the partial-token and illegal-code cases. Finally, a three-cell chain with random handshake delays is scored against a queue of expected values.

// File: rtl/hb_cell_pkg.sv
package hb_cell_pkg;

  localparam int unsigned HB_LANES = 3;

  typedef enum logic [1:0] {
    FN_BUF  = 2'd0,
    FN_AND2 = 2'd1,
    FN_XOR2 = 2'd2,
    FN_AO3  = 2'd3
  } hb_func_e;

  // number of lanes a function consumes
  function automatic int unsigned hb_used(hb_func_e f);
    case (f)
      FN_BUF:  return 1;
      FN_AND2: return 2;
      FN_XOR2: return 2;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/hb_complete.sv
module hb_complete
  import hb_cell_pkg::*;
#(
  parameter int unsigned USED = 3
) (
  input  logic [HB_LANES-1:0] in_t,
  input  logic [HB_LANES-1:0] in_f,
  output logic                all_valid,
  output logic                all_empty
);
  localparam logic [HB_LANES-1:0] MASK = HB_LANES'((1 << USED) - 1);

  logic [HB_LANES-1:0] lane_valid;
  logic [HB_LANES-1:0] lane_empty;

  for (genvar i = 0; i < HB_LANES; i++) begin : g_lane
    assign lane_valid[i] = in_t[i] ^ in_f[i];
    assign lane_empty[i] = ~(in_t[i] | in_f[i]);
  end

  // lanes outside the mask always count as both valid and empty
  assign all_valid = &(lane_valid | ~MASK);
  assign all_empty = &(lane_empty | ~MASK);
endmodule

// File: rtl/hb_rail_fn.sv
module hb_rail_fn
  import hb_cell_pkg::*;
#(
  parameter hb_func_e FUNC = FN_AO3
) (
  input  logic [HB_LANES-1:0] in_t,
  input  logic [HB_LANES-1:0] in_f,
  output logic                fn_t,
  output logic                fn_f
);
  logic buf_t, buf_f, and_t, and_f, xor_t, xor_f, ao_t, ao_f;

  always_comb begin
    buf_t = in_t[0];
    buf_f = in_f[0];
    and_t = in_t[0] & in_t[1];
    and_f = in_f[0] | in_f[1];
    xor_t = (in_t[0] & in_f[1]) | (in_f[0] & in_t[1]);
    xor_f = (in_t[0] & in_t[1]) | (in_f[0] & in_f[1]);
    ao_t  = (in_t[0] & in_t[1]) | in_t[2];
    ao_f  = (in_f[0] | in_f[1]) & in_f[2];
    case (FUNC)
      FN_BUF:  begin fn_t = buf_t; fn_f = buf_f; end
      FN_AND2: begin fn_t = and_t; fn_f = and_f; end
      FN_XOR2: begin fn_t = xor_t; fn_f = xor_f; end
      default: begin fn_t = ao_t;  fn_f = ao_f;  end
    endcase
  end
endmodule

// File: rtl/hb_cell.sv
module hb_cell
  import hb_cell_pkg::*;
#(
  parameter hb_func_e FUNC = FN_AO3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [HB_LANES-1:0] in_t,
  input  logic [HB_LANES-1:0] in_f,
  input  logic                rack,
  output logic                out_t,
  output logic                out_f,
  output logic                out_tn,
  output logic                out_fn,
  output logic                lack,
  output logic                lack_n
);
  localparam int unsigned USED = hb_used(FUNC);

  logic all_valid, all_empty;
  logic fn_t, fn_f;
  logic q_t, q_f;
  logic q_valid;

  hb_complete #(.USED(USED)) u_complete (
    .in_t      (in_t),
    .in_f      (in_f),
    .all_valid (all_valid),
    .all_empty (all_empty)
  );

  hb_rail_fn #(.FUNC(FUNC)) u_fn (
    .in_t (in_t),
    .in_f (in_f),
    .fn_t (fn_t),
    .fn_f (fn_f)
  );

  assign q_valid = q_t | q_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_t <= 1'b0;
      q_f <= 1'b0;
    end else if (!q_valid && all_valid && !rack) begin
      q_t <= fn_t;
      q_f <= fn_f;
    end else if (q_valid && all_empty && rack) begin
      q_t <= 1'b0;
      q_f <= 1'b0;
    end
  end

  assign out_t  = q_t;
  assign out_f  = q_f;
  assign out_tn = ~q_t;
  assign out_fn = ~q_f;
  assign lack   = q_valid;
  assign lack_n = ~q_valid;

  AST_NO_ILLEGAL_OUT: assert property (@(posedge clk) disable iff (rst)
    !(out_t && out_f)); // R1

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (!out_t && !out_f && !lack)); // R2

  AST_LOAD_GUARDED: assert property (@(posedge clk) disable iff (rst)
    $rose(lack) |-> $past(all_valid && !rack)); // R3

  AST_CLEAR_GUARDED: assert property (@(posedge clk) disable iff (rst)
    ($fell(lack) && !$past(rst)) |-> $past(all_empty && rack)); // R4

  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (rst)
    ($past(lack) && lack) |-> ($stable(out_t) && $stable(out_f))); // R5

endmodule

// File: tb/hb_cell_tb.sv
module hb_cell_tb;
  import hb_cell_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int nchk = 0, nfail = 0;
  bit done = 0;

  // directed cells: 0 buf, 1 and, 2 xor, 3 and-or (u_dut)
  logic       rst = 1'b1;
  logic [2:0] d_t = '0, d_f = '0;
  logic       d_rack = 1'b0;
  logic [3:0] ot, of, otn, ofn, ak, akn;

  hb_cell #(.FUNC(FN_BUF)) u_buf (.clk(clk), .rst(rst), .in_t(d_t), .in_f(d_f), .rack(d_rack),
    .out_t(ot[0]), .out_f(of[0]), .out_tn(otn[0]), .out_fn(ofn[0]), .lack(ak[0]), .lack_n(akn[0]));
  hb_cell #(.FUNC(FN_AND2)) u_and (.clk(clk), .rst(rst), .in_t(d_t), .in_f(d_f), .rack(d_rack),
    .out_t(ot[1]), .out_f(of[1]), .out_tn(otn[1]), .out_fn(ofn[1]), .lack(ak[1]), .lack_n(akn[1]));
  hb_cell #(.FUNC(FN_XOR2)) u_xor (.clk(clk), .rst(rst), .in_t(d_t), .in_f(d_f), .rack(d_rack),
    .out_t(ot[2]), .out_f(of[2]), .out_tn(otn[2]), .out_fn(ofn[2]), .lack(ak[2]), .lack_n(akn[2]));
  hb_cell #(.FUNC(FN_AO3)) u_dut (.clk(clk), .rst(rst), .in_t(d_t), .in_f(d_f), .rack(d_rack),
    .out_t(ot[3]), .out_f(of[3]), .out_tn(otn[3]), .out_fn(ofn[3]), .lack(ak[3]), .lack_n(akn[3]));

  // chain: and2 -> buf -> buf
  logic [1:0] pa_t = '0, pa_f = '0;
  logic       c_rack = 1'b0;
  logic [2:0] ct, cf, ctn, cfn, cak, cakn;

  hb_cell #(.FUNC(FN_AND2)) u_c0 (.clk(clk), .rst(rst), .in_t({1'b0, pa_t}), .in_f({1'b0, pa_f}),
    .rack(cak[1]), .out_t(ct[0]), .out_f(cf[0]), .out_tn(ctn[0]), .out_fn(cfn[0]), .lack(cak[0]), .lack_n(cakn[0]));
  hb_cell #(.FUNC(FN_BUF)) u_c1 (.clk(clk), .rst(rst), .in_t({2'b00, ct[0]}), .in_f({2'b00, cf[0]}),
    .rack(cak[2]), .out_t(ct[1]), .out_f(cf[1]), .out_tn(ctn[1]), .out_fn(cfn[1]), .lack(cak[1]), .lack_n(cakn[1]));
  hb_cell #(.FUNC(FN_BUF)) u_c2 (.clk(clk), .rst(rst), .in_t({2'b00, ct[1]}), .in_f({2'b00, cf[1]}),
    .rack(c_rack), .out_t(ct[2]), .out_f(cf[2]), .out_tn(ctn[2]), .out_fn(cfn[2]), .lack(cak[2]), .lack_n(cakn[2]));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [1:0] model(int f, logic a, logic b, logic c);
    logic v;
    case (f)
      0: v = a;
      1: v = a & b;
      2: v = a ^ b;
      default: v = (a & b) | c;
    endcase
    return {v, ~v};
  endfunction

  function automatic logic [1:0] pair(int k);
    return {ot[k], of[k]};
  endfunction

  task automatic clear_all();
    d_t = '0; d_f = '0; d_rack = 1'b1; step();
    d_rack = 1'b0; step();
  endtask

  // illegal code monitor on the chain source
  always @(negedge clk)
    if (!rst && (pa_t & pa_f) != 2'b00) begin
      nchk++; nfail++;
      $display("FAIL R1 illegal chain input actual=%0h expected=0", pa_t & pa_f);
    end

  logic exp_q[$];
  localparam int NTOK = 40;
  int got = 0;

  initial begin
    repeat (3) step();
    // R2 reset state and R8 complements
    check("R2 reset pair", pair(3), 2'b00);
    check("R2 reset lack", ak, 4'h0);
    check("R8 reset complements", {otn[3], ofn[3], akn[3]}, 3'b111);
    rst = 1'b0; step();

    // R3/R7/R5/R4 over every input combination
    for (int v = 0; v < 8; v++) begin
      logic a, b, c;
      a = v[0]; b = v[1]; c = v[2];
      d_t = {c, b, a}; d_f = ~{c, b, a}; d_rack = 1'b0; step();
      for (int k = 0; k < 4; k++) check($sformatf("R7 func %0d in %0d", k, v), pair(k), model(k, a, b, c));
      check("R3 lack raised", ak[3], 1'b1);
      check("R8 complements valid", {otn[3], ofn[3], akn[3]}, {~ot[3], ~of[3], 1'b0});
      d_rack = 1'b1; step();
      check("R5 hold with rack high", pair(3), model(3, a, b, c));
      d_t = '0; d_f = '0; step();
      check("R4 cleared", {pair(3), ak[3]}, 3'b000);
      d_rack = 1'b0; step();
    end

    // R6 partial token: C true alone, A and B empty
    d_t = 3'b100; d_f = 3'b000; step();
    check("R6 partial C only", {pair(3), ak[3]}, 3'b000);
    // R6 / R9: A,B valid, C empty -> and-or waits, and2 loads
    d_t = 3'b011; d_f = 3'b000; step();
    check("R6 partial A B", {pair(3), ak[3]}, 3'b000);
    check("R9 and2 ignores lane 2", pair(1), 2'b10);
    check("R9 buf ignores lanes 1 2", pair(0), 2'b10);
    clear_all();
    // R9: buffer clears while unused lanes still valid
    d_t = 3'b110; d_f = 3'b001; step();
    check("R9 buf loads with other lanes", pair(0), 2'b01);
    d_t = 3'b110; d_f = 3'b000; d_rack = 1'b1; step();
    check("R9 buf clears despite lanes 1 2", pair(0), 2'b00);
    check("R5 and-or holds mixed lanes", pair(3), 2'b10);
    clear_all();

    // R10 illegal lane code
    d_t = 3'b111; d_f = 3'b001; step();
    check("R10 no load on 11", {pair(3), ak[3]}, 3'b000);
    d_t = 3'b111; d_f = 3'b000; step();
    check("R10 loads after fix", pair(3), 2'b10);
    d_t = 3'b001; d_f = 3'b001; d_rack = 1'b1; step();
    check("R10 no clear on 11", pair(3), 2'b10);
    clear_all();
    check("R4 cleared after illegal", pair(3), 2'b00);

    // R5 rack high blocks load
    d_rack = 1'b1; d_t = 3'b000; d_f = 3'b111; step();
    check("R5 no load with rack high", {pair(3), ak[3]}, 3'b000);
    d_rack = 1'b0; step();
    check("R3 load after rack low", pair(3), 2'b01);
    // R2 reset while valid
    rst = 1'b1; step();
    check("R2 reset mid token", {pair(3), ak[3]}, 3'b000);
    rst = 1'b0; d_t = '0; d_f = '0; step();

    // R11 chain with random handshake delays
    fork
      begin
        for (int i = 0; i < NTOK; i++) begin
          logic a, b;
          while (cak[0]) step();
          a = 1'($urandom_range(0, 1)); b = 1'($urandom_range(0, 1));
          pa_t = {b, a}; pa_f = ~{b, a};
          exp_q.push_back(a & b);
          while (!cak[0]) step();
          repeat ($urandom_range(0, 3)) step();
          pa_t = '0; pa_f = '0;
        end
      end
      begin
        for (int i = 0; i < NTOK; i++) begin
          logic e;
          while (!(ct[2] | cf[2])) step();
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'bx;
          check("R11 chain token", {ct[2], cf[2]}, {e, ~e});
          got++;
          repeat ($urandom_range(0, 3)) step();
          c_rack = 1'b1;
          while (ct[2] | cf[2]) step();
          repeat ($urandom_range(0, 3)) step();
          c_rack = 1'b0;
        end
      end
    join
    step();
    check("R11 token count", 8'(got), 8'(NTOK));
    check("R11 queue drained", 8'(exp_q.size()), 8'd0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule